// File: doc/BRIEF.md
# Peripheral Ready Wait-State Generator

This block sits on the target side of an 8-bit XT-style system bus and lengthens the bus cycles of one slow peripheral. A cycle starts at T1. The block sees this as ALE high while the decoded select for its peripheral is also high. From the next clock it pulls the bus ready line low. It then counts bus clocks. It lets ready go high again once the fixed pipeline moves and the programmed number of extra wait states have elapsed.

Ready is given as two signals. The first is an open-drain style enable, which the pad uses to drive the line. The second is the level to drive. When the block is not stretching a cycle, it stops driving, so the line's pull-up leaves it high. The extra wait count is sampled at T1. After the release, the block stays busy until both command strobes have returned high, and only then does it accept a new cycle.

The block has no streaming data path, so it has no valid/ready handshake and no back-pressure rules. All of its pins are plain control signals.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is asserted and directly after it, `rdy_oe` is 0 and `rdy_lvl` is 1.
- R2: A clock edge at which the block is idle and both `ale` and `cs` are 1 marks T1. From the following clock, `rdy_oe` is 1 and `rdy_lvl` is 0.
- R3: With `wait_cnt` = 0 at T1, ready is held low for exactly 3 clocks: T2, T3 and a single Tw.
- R4: Each unit of `wait_cnt` adds one low clock, so the low time is 3 + `wait_cnt` clocks. This holds up to the maximum of 15, which gives 18 low clocks.
- R5: `wait_cnt` is sampled only at T1. Changing it later in the cycle does not alter the low time of that cycle.
- R6: An `ale` and `cs` pair seen while a cycle is being held low does not restart or lengthen that cycle.
- R7: After the release, the block does not start a new cycle until both `cmd_rd_n` and `cmd_wr_n` are 1 (inactive) at a clock edge. An `ale` and `cs` pair seen before then gives no new low period.
- R8: `rdy_lvl` is always the inverse of `rdy_oe`. The level is low only while the line is being driven.
- R9: `ale` high without `cs` never starts a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale | input | 1 | Address latch enable, high during T1 |
| cs | input | 1 | Decoded select for this peripheral, active high |
| cmd_rd_n | input | 1 | Read command strobe, active low |
| cmd_wr_n | input | 1 | Write command strobe, active low |
| wait_cnt | input | 4 | Number of extra wait states, sampled at T1 |
| rdy_oe | output | 1 | Drive enable for the ready line (1 = pull low) |
| rdy_lvl | output | 1 | Level for the ready line (0 while driven, 1 otherwise) |

## Verification
Two events can fall in the same clock:
- A new start (ALE with select) can arrive while a stretch is running, or in the clock where the block is waiting for the strobes to end.
- A change of the wait count can land in the middle of a stretch.

The bench provokes these cases in three ways. It raises ALE and select during the low period. It raises them again after the release while a strobe is still held. It inverts `wait_cnt` right after T1.

A behavioural model in the bench is compared with both outputs on every clock. The bench also counts the low clocks of each cycle and checks that the count equals 3 plus the value sampled at T1. In the cases above, it checks that no extra low clock appears.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  localparam int unsigned PIPE_CLKS = 3;  // T1->T2, T2->T3, T3->first Tw
endpackage

// File: rtl/bwg_start_det.sv
module bwg_start_det
  import bwg_pkg::*;
(
  input  phase_t phase,
  input  logic   ale,
  input  logic   cs,
  output logic   start
);
  // A start is honoured only from idle; ALE without select is not ours.
  always_comb start = (phase == PH_IDLE) && ale && cs;
endmodule

// File: rtl/bwg_wait_timer.sv
module bwg_wait_timer
  import bwg_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hold,
  input  logic [WAIT_W-1:0] wait_in,
  output logic              expire
);
  localparam int unsigned MAX_T = PIPE_CLKS + (2 ** WAIT_W) - 1;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;
  logic             in_tw;

  // Comparison only counts once the pipeline clocks are done.
  always_comb begin
    in_tw  = cnt_q >= CNT_W'(PIPE_CLKS);
    expire = hold && in_tw && (cnt_q >= tgt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(1);
      tgt_q <= CNT_W'(PIPE_CLKS) + CNT_W'(wait_in);
    end else if (hold && !expire) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (cnt_q <= tgt_q));

  // R5
  tgt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(tgt_q));
endmodule

// File: rtl/bwg_phase_fsm.sv
module bwg_phase_fsm
  import bwg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   expire,
  input  logic   cmd_rd_n,
  input  logic   cmd_wr_n,
  output phase_t phase
);
  logic cmd_act;
  phase_t phase_d;

  always_comb begin
    cmd_act = !cmd_rd_n || !cmd_wr_n;
    phase_d = phase;
    unique case (phase)
      PH_IDLE: if (start)    phase_d = PH_HOLD;
      PH_HOLD: if (expire)   phase_d = PH_DONE;
      PH_DONE: if (!cmd_act) phase_d = PH_IDLE;
      default:               phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  // R7
  strobe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && cmd_act) |=> (phase == PH_DONE));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && !expire) |=> (phase == PH_HOLD));
endmodule

// File: rtl/bwg_rdy_drive.sv
module bwg_rdy_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic expire,
  output logic rdy_oe,
  output logic rdy_lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_oe  <= 1'b0;
      rdy_lvl <= 1'b1;
    end else if (start) begin
      rdy_oe  <= 1'b1;
      rdy_lvl <= 1'b0;
    end else if (expire) begin
      rdy_oe  <= 1'b0;
      rdy_lvl <= 1'b1;
    end
  end

  // R8
  lvl_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_lvl == !rdy_oe);
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              cs,
  input  logic              cmd_rd_n,
  input  logic              cmd_wr_n,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic              rdy_oe,
  output logic              rdy_lvl
);
  phase_t phase;
  logic   start;
  logic   expire;
  logic   hold;

  always_comb hold = (phase == PH_HOLD);

  bwg_start_det u_start (
    .phase (phase),
    .ale   (ale),
    .cs    (cs),
    .start (start)
  );

  bwg_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .hold    (hold),
    .wait_in (wait_cnt),
    .expire  (expire)
  );

  bwg_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .expire   (expire),
    .cmd_rd_n (cmd_rd_n),
    .cmd_wr_n (cmd_wr_n),
    .phase    (phase)
  );

  bwg_rdy_drive u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .expire  (expire),
    .rdy_oe  (rdy_oe),
    .rdy_lvl (rdy_lvl)
  );

  // R2
  t1_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && ale && cs) |=> (rdy_oe && !rdy_lvl));

  // R9
  no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !cs) |=> !rdy_oe);
endmodule

// File: tb/test_bus_wait_gen.sv
`timescale 1ns/1ps
module test_bus_wait_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic       cs = 1'b0;
  logic       cmd_rd_n = 1'b1;
  logic       cmd_wr_n = 1'b1;
  logic [3:0] wait_cnt = 4'd0;
  logic       rdy_oe;
  logic       rdy_lvl;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bus_wait_gen i_bus_wait_gen (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs(cs),
    .cmd_rd_n(cmd_rd_n), .cmd_wr_n(cmd_wr_n), .wait_cnt(wait_cnt),
    .rdy_oe(rdy_oe), .rdy_lvl(rdy_lvl)
  );

  // Behavioural reference: mode 0 idle, 1 stretching, 2 awaiting strobe end
  int m_mode = 0;
  int m_elapsed = 0;
  int m_target = 0;

  always @(posedge clk) begin
    if (!rst_n) m_mode = 0;
    else begin
      case (m_mode)
        0: if (ale && cs) begin m_mode = 1; m_elapsed = 1; m_target = 3 + int'(wait_cnt); end
        1: if (m_elapsed >= m_target) m_mode = 2; else m_elapsed++;
        default: if (cmd_rd_n && cmd_wr_n) m_mode = 0;
      endcase
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison of both outputs (R2, R8)
  always @(negedge clk) begin
    if (cmp_on) begin
      check(rdy_oe == (m_mode == 1), "R2 rdy_oe vs model", rdy_oe, m_mode == 1);
      check(rdy_lvl == !rdy_oe, "R8 rdy_lvl inverse", rdy_lvl, !rdy_oe);
    end
  end

  // One bus cycle; returns measured low clocks and any low seen afterwards
  task automatic bus_cycle(int n, int extra, bit mid_change, bit poke_hold,
                           bit poke_done, output int low, output int late);
    @(negedge clk); ale = 1; cs = 1; wait_cnt = 4'(n);
    @(negedge clk); ale = 0; cmd_rd_n = 0;
    if (mid_change) wait_cnt = ~4'(n);
    low = 0; late = 0;
    while (rdy_oe && low < 40) begin
      low++;
      ale = poke_hold && (low == 2);
      @(negedge clk);
    end
    ale = 0;
    for (int k = 0; k < extra; k++) begin
      ale = poke_done && (k == 1);
      @(negedge clk);
      if (rdy_oe) late++;
    end
    ale = 0; cs = 0; cmd_rd_n = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int low, late;
    repeat (3) @(negedge clk);
    check(rdy_oe == 0 && rdy_lvl == 1, "R1 reset state", rdy_oe, 0);
    rst_n = 1;
    @(negedge clk);
    check(rdy_oe == 0 && rdy_lvl == 1, "R1 after reset", rdy_oe, 0);
    cmp_on = 1;

    bus_cycle(0, 2, 0, 0, 0, low, late);
    check(low == 3, "R3 zero waits low clocks", low, 3);
    bus_cycle(1, 2, 0, 0, 0, low, late);
    check(low == 4, "R4 one wait", low, 4);
    bus_cycle(5, 2, 0, 0, 0, low, late);
    check(low == 8, "R4 five waits", low, 8);
    bus_cycle(15, 2, 0, 0, 0, low, late);
    check(low == 18, "R4 max waits", low, 18);
    bus_cycle(2, 2, 1, 0, 0, low, late);
    check(low == 5, "R5 mid-cycle wait change", low, 5);
    bus_cycle(4, 2, 0, 1, 0, low, late);
    check(low == 7, "R6 start during hold ignored", low, 7);
    bus_cycle(3, 6, 0, 0, 1, low, late);
    check(low == 6, "R7 cycle length", low, 6);
    check(late == 0, "R7 start before strobe end ignored", late, 0);

    // R9: ALE without select
    @(negedge clk); ale = 1; cs = 0;
    @(negedge clk); ale = 0;
    @(negedge clk);
    check(rdy_oe == 0, "R9 ale without cs", rdy_oe, 0);

    // Write strobe variant, back-to-back after idle
    @(negedge clk); ale = 1; cs = 1; wait_cnt = 4'd0;
    @(negedge clk); ale = 0; cmd_wr_n = 0;
    check(rdy_oe == 1 && rdy_lvl == 0, "R2 pull low after T1", rdy_oe, 1);
    repeat (5) @(negedge clk);
    cmd_wr_n = 1; cs = 0;
    repeat (3) @(negedge clk);
    check(rdy_oe == 0, "R7 idle after write strobe end", rdy_oe, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule